// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Encoded Invalidation

This block is a small, fully associative cache of virtual-page to physical-page translations for an I/O memory management unit. Each entry holds one 4 KB page mapping tagged with a 7-bit address-space identifier, together with readable, writable and non-secure attribute bits. A lookup presents an identifier and a 32-bit virtual address. On a hit the physical address (frame number joined to the page offset) and the attributes come back in the same cycle. On a miss the block raises a walk request toward an external table walker and waits for its fill.

Invalidation is driven by one 32-bit command word, written with a single-cycle strobe. The command can drop every entry, every entry inside one 4 MB section, or every entry inside one 16 KB group, and each of these may be narrowed to a single identifier. A configuration word sets how many lines take part in caching, whether hits are served while a walk is outstanding, and the replacement policy.

The controller has two states. Idle (`ST_IDLE`) accepts lookups freely. A miss accepted in Idle takes the transition "miss accepted" into Walk pending (`ST_WAIT`), which holds the walk request. Any fill strobe takes the transition "fill returned" back to Idle, whether the fill is stored or discarded.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, the controller is in Idle with `lk_ready` high and `walk_req` low, and the configuration reads as hit-under-miss on, round-robin on and the line count equal to the entry count (clamped to 63).
- R2: A lookup hits when a valid entry among the active lines has the same identifier and the same virtual page number (VA[31:12]). `lk_hit` rises in the same cycle, with `lk_pa` = {frame, VA[11:0]} and `lk_attr` = {readable, writable, non-secure} at bits 2, 1 and 0. Any other accepted lookup raises `lk_miss`, and never both.
- R3: The cycle after an accepted miss, `walk_req` is high and `walk_asid` and `walk_va` (page aligned) hold the missed identifier and page until `fill_valid`. A fill with no coincident flush stores `fill_pfn` and `fill_attr` under that tag.
- R4: With configuration bit 28 set, each stored fill goes to the line at a rotating pointer. The pointer advances by one and wraps to 0 at the active line count, and a pointer at or beyond the count is treated as 0.
- R5: With configuration bit 28 clear, a fill goes to the lowest-numbered invalid active line and leaves the pointer alone. Only when no active line is free does it use and advance the pointer as in R4.
- R6: With configuration bit 29 set, a lookup that hits while a walk is pending is accepted and answered. A lookup that misses then is stalled (`lk_ready` low, no `lk_miss`). With bit 29 clear, every lookup is stalled while a walk is pending.
- R7: Flush word bits [1:0] pick the scope. 0 drops all pages. 2 drops pages whose VA[31:22] equals word[19:10]. 3 drops pages whose VA[31:14] equals word[19:2]. 1 drops nothing, and any command with a bit of word[23:20] set drops nothing.
- R8: When flush word bit 31 is set, only entries whose identifier equals word[30:24] are dropped. When it is clear, the identifier is not compared.
- R9: A flush strobe in the same cycle as `fill_valid` wins. The fill is discarded, nothing is stored, and the controller still returns to Idle.
- R10: Configuration bits [5:0] give the active line count, clamped to the entry count. Only lines below it are looked up or filled, a count of 0 caches nothing, and a configuration write invalidates every line at or above its new count. A configuration write with any bit other than 29, 28 and [5:0] set is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 32 | Configuration word: bit 29 hit-under-miss, bit 28 round-robin, [5:0] line count |
| flush_wr | input | 1 | Flush command strobe |
| flush_word | input | 32 | Encoded flush command |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_va | input | 32 | Lookup virtual address |
| lk_ready | output | 1 | Lookup accepted this cycle (low means stall) |
| lk_hit | output | 1 | Accepted lookup hit |
| lk_miss | output | 1 | Accepted lookup missed, walk starts |
| lk_pa | output | PFN_W+12 | Physical address on a hit |
| lk_attr | output | 3 | {readable, writable, non-secure} on a hit |
| walk_req | output | 1 | Walk outstanding |
| walk_asid | output | 7 | Identifier of the outstanding walk |
| walk_va | output | 32 | Page-aligned virtual address of the outstanding walk |
| fill_valid | input | 1 | Walker returns a translation |
| fill_pfn | input | PFN_W | Returned frame number |
| fill_attr | input | 3 | Returned {readable, writable, non-secure} |

## Verification
The assertions assume the walker raises `fill_valid` only while `walk_req` is high and the requester keeps a stalled lookup stable. The stimulus drives each fill strictly inside a pending walk. Lookups are used to observe whether a page is still cached. A lookup that misses starts a walk, and the stimulus closes that walk with a fill that coincides with a reserved-scope flush, which stores nothing and drops nothing, so the cache contents the sweep depends on stay as they were.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int ASID_W     = 7;
    localparam int ATTR_W     = 3;

    // configuration word fields
    localparam int CFG_HUM_BIT = 29;
    localparam int CFG_RR_BIT  = 28;
    localparam int CFG_LINES_W = 6;

    // flush word fields
    localparam int FW_ASID_EN_BIT = 31;
    localparam int FW_ASID_LSB    = 24;

    typedef enum logic [1:0] {
        FL_ALL     = 2'd0,
        FL_RSVD    = 2'd1,
        FL_SECTION = 2'd2,
        FL_GROUP   = 2'd3
    } flush_kind_e;

    typedef struct packed {
        logic              en;
        logic              asid_en;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  key;
        logic [VPN_W-1:0]  mask;
    } flush_cmd_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/tlb_flush_dec.sv
module tlb_flush_dec
    import asid_tlb_pkg::*;
(
    input  logic        strobe,
    input  logic [31:0] word,
    output flush_cmd_t  cmd
);

    logic rsvd_clear;

    assign rsvd_clear = (word[23:20] == 4'd0);

    always_comb begin
        cmd.asid_en = word[FW_ASID_EN_BIT];
        cmd.asid    = word[FW_ASID_LSB +: ASID_W];
        cmd.key     = word[VPN_W-1:0];
        unique case (flush_kind_e'(word[1:0]))
            FL_ALL: begin
                cmd.en   = strobe && rsvd_clear;
                cmd.mask = '0;
            end
            FL_SECTION: begin
                cmd.en   = strobe && rsvd_clear;
                cmd.mask = {{(VPN_W-10){1'b1}}, 10'd0};
            end
            FL_GROUP: begin
                cmd.en   = strobe && rsvd_clear;
                cmd.mask = {{(VPN_W-2){1'b1}}, 2'd0};
            end
            default: begin
                cmd.en   = 1'b0;
                cmd.mask = '0;
            end
        endcase
    end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [CNT_W-1:0]  eff_lines,
    input  logic              rr_mode,
    input  flush_cmd_t        cmd,
    input  logic              cfg_apply,
    input  logic [CNT_W-1:0]  new_lines,
    input  logic              wr_en,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [ATTR_W-1:0] wr_attr,
    output logic              hit,
    output logic [PFN_W-1:0]  hit_pfn,
    output logic [ATTR_W-1:0] hit_attr
);

    logic [ENTRIES-1:0] vld, act, match, free;
    logic [PFN_W-1:0]   e_pfn  [ENTRIES];
    logic [ATTR_W-1:0]  e_attr [ENTRIES];

    logic [IDX_W-1:0] ptr, ptr_c, first_free, victim;
    logic             any_free, use_free, wr_go;
    logic [CNT_W-1:0] ptr_nxt;

    assign wr_go = wr_en && (eff_lines != '0);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic              v;
        logic [ASID_W-1:0] a;
        logic [VPN_W-1:0]  p;
        logic [PFN_W-1:0]  f;
        logic [ATTR_W-1:0] t;
        logic              kill, wsel;

        assign act[i]   = CNT_W'(i) < eff_lines;
        assign match[i] = act[i] && v && (a == lk_asid) && (p == lk_vpn);
        assign free[i]  = act[i] && !v;
        assign kill     = (cmd.en && (!cmd.asid_en || (a == cmd.asid))
                           && (((p ^ cmd.key) & cmd.mask) == '0))
                        || (cfg_apply && !(CNT_W'(i) < new_lines));
        assign wsel     = wr_go && (victim == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v <= 1'b0;
            end else if (kill) begin
                v <= 1'b0;
            end else if (wsel) begin
                v <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wsel && !kill) begin
                a <= wr_asid;
                p <= wr_vpn;
                f <= wr_pfn;
                t <= wr_attr;
            end
        end

        assign vld[i]    = v;
        assign e_pfn[i]  = f;
        assign e_attr[i] = t;
    end

    always_comb begin
        hit      = 1'b0;
        hit_pfn  = '0;
        hit_attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_pfn  = hit_pfn | e_pfn[i];
                hit_attr = hit_attr | e_attr[i];
            end
        end
    end

    always_comb begin
        first_free = '0;
        any_free   = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free[i]) begin
                first_free = IDX_W'(i);
                any_free   = 1'b1;
            end
        end
    end

    assign ptr_c    = (CNT_W'(ptr) < eff_lines) ? ptr : '0;
    assign use_free = !rr_mode && any_free;
    assign victim   = use_free ? first_free : ptr_c;
    assign ptr_nxt  = CNT_W'(ptr_c) + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_go && !use_free) begin
            ptr <= (ptr_nxt >= eff_lines) ? '0 : IDX_W'(ptr_nxt);
        end
    end

    logic unused_vld;
    assign unused_vld = ^vld;

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import asid_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              hit,
    input  logic              hum_en,
    input  logic              fill_valid,
    input  logic              flush_strobe,
    output logic              lk_ready,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              walk_req,
    output logic [ASID_W-1:0] walk_asid,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic              fill_take
);

    ctrl_state_e state, state_nxt;

    // state register and pending-walk capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            walk_asid <= '0;
            walk_vpn  <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && lk_miss) begin
                walk_asid <= lk_asid;
                walk_vpn  <= lk_vpn;
            end
        end
    end

    // transitions: miss accepted, fill returned
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (lk_miss)    state_nxt = ST_WAIT;
            ST_WAIT: if (fill_valid) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                lk_ready  = 1'b1;
                walk_req  = 1'b0;
                fill_take = 1'b0;
            end
            ST_WAIT: begin
                lk_ready  = hum_en && hit;
                walk_req  = 1'b1;
                fill_take = fill_valid && !flush_strobe;
            end
            default: begin
                lk_ready  = 1'b0;
                walk_req  = 1'b0;
                fill_take = 1'b0;
            end
        endcase
        lk_hit  = lk_valid && lk_ready && hit;
        lk_miss = lk_valid && lk_ready && !hit;
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 20
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [31:0]             cfg_word,
    input  logic                    flush_wr,
    input  logic [31:0]             flush_word,
    input  logic                    lk_valid,
    input  logic [6:0]              lk_asid,
    input  logic [31:0]             lk_va,
    output logic                    lk_ready,
    output logic                    lk_hit,
    output logic                    lk_miss,
    output logic [PFN_W+11:0]       lk_pa,
    output logic [2:0]              lk_attr,
    output logic                    walk_req,
    output logic [6:0]              walk_asid,
    output logic [31:0]             walk_va,
    input  logic                    fill_valid,
    input  logic [PFN_W-1:0]        fill_pfn,
    input  logic [2:0]              fill_attr
);

    localparam int CNT_W     = $clog2(ENTRIES + 1);
    localparam int LINES_MAX = (ENTRIES > 63) ? 63 : ENTRIES;

    function automatic logic [CNT_W-1:0] clamp_lines(input logic [CFG_LINES_W-1:0] n);
        if (int'(n) > ENTRIES) return CNT_W'(ENTRIES);
        else                   return CNT_W'(n);
    endfunction

    logic                   cfg_hum, cfg_rr;
    logic [CFG_LINES_W-1:0] cfg_lines;
    logic                   cfg_apply, caching_off;
    logic [CNT_W-1:0]       eff_lines, new_lines;
    flush_cmd_t             fcmd;
    logic                   st_hit, fill_take;
    logic [PFN_W-1:0]       st_pfn;
    logic [ATTR_W-1:0]      st_attr;
    logic [VPN_W-1:0]       walk_vpn;

    assign cfg_apply = cfg_wr && (cfg_word[31:30] == 2'd0) && (cfg_word[27:6] == '0);
    assign new_lines = clamp_lines(cfg_word[CFG_LINES_W-1:0]);
    assign eff_lines = clamp_lines(cfg_lines);
    assign caching_off = (eff_lines == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_hum   <= 1'b1;
            cfg_rr    <= 1'b1;
            cfg_lines <= CFG_LINES_W'(LINES_MAX);
        end else if (cfg_apply) begin
            cfg_hum   <= cfg_word[CFG_HUM_BIT];
            cfg_rr    <= cfg_word[CFG_RR_BIT];
            cfg_lines <= cfg_word[CFG_LINES_W-1:0];
        end
    end

    tlb_flush_dec u_dec (
        .strobe (flush_wr),
        .word   (flush_word),
        .cmd    (fcmd)
    );

    tlb_store #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_asid   (lk_asid),
        .lk_vpn    (lk_va[VA_W-1:PAGE_SHIFT]),
        .eff_lines (eff_lines),
        .rr_mode   (cfg_rr),
        .cmd       (fcmd),
        .cfg_apply (cfg_apply),
        .new_lines (new_lines),
        .wr_en     (fill_take),
        .wr_asid   (walk_asid),
        .wr_vpn    (walk_vpn),
        .wr_pfn    (fill_pfn),
        .wr_attr   (fill_attr),
        .hit       (st_hit),
        .hit_pfn   (st_pfn),
        .hit_attr  (st_attr)
    );

    tlb_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_valid     (lk_valid),
        .lk_asid      (lk_asid),
        .lk_vpn       (lk_va[VA_W-1:PAGE_SHIFT]),
        .hit          (st_hit),
        .hum_en       (cfg_hum),
        .fill_valid   (fill_valid),
        .flush_strobe (flush_wr),
        .lk_ready     (lk_ready),
        .lk_hit       (lk_hit),
        .lk_miss      (lk_miss),
        .walk_req     (walk_req),
        .walk_asid    (walk_asid),
        .walk_vpn     (walk_vpn),
        .fill_take    (fill_take)
    );

    assign lk_pa   = lk_hit ? {st_pfn, lk_va[PAGE_SHIFT-1:0]} : '0;
    assign lk_attr = lk_hit ? st_attr : '0;
    assign walk_va = {walk_vpn, {PAGE_SHIFT{1'b0}}};

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic        lk_ready,
    input logic        lk_hit,
    input logic        lk_miss,
    input logic        walk_req,
    input logic [6:0]  walk_asid,
    input logic [31:0] walk_va,
    input logic        fill_valid,
    input logic        cfg_hum,
    input logic        caching_off
);

    // R2
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss}));

    // R2
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_valid);

    // R3
    miss_starts_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |=> walk_req);

    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid) |=> (walk_req && $stable(walk_va) && $stable(walk_asid)));

    // R9
    fill_closes_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid) |=> !walk_req);

    // R6
    stall_no_hum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !cfg_hum) |-> !lk_ready);

    // R10
    off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        caching_off |-> !lk_hit);

endmodule

bind asid_tlb asid_tlb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_ready    (lk_ready),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .walk_req    (walk_req),
    .walk_asid   (walk_asid),
    .walk_va     (walk_va),
    .fill_valid  (fill_valid),
    .cfg_hum     (cfg_hum),
    .caching_off (caching_off)
);

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;

    localparam int CLK_PERIOD = 10;
    localparam int PFN_W = 20;
    localparam logic [11:0] OFS = 12'hA5C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, flush_wr = 1'b0, lk_valid = 1'b0, fill_valid = 1'b0;
    logic [31:0] cfg_word = '0, flush_word = '0, lk_va = '0;
    logic [6:0] lk_asid = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic [2:0] fill_attr = '0;
    logic lk_ready, lk_hit, lk_miss, walk_req;
    logic [PFN_W+11:0] lk_pa;
    logic [2:0] lk_attr;
    logic [6:0] walk_asid;
    logic [31:0] walk_va;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic s_hit, s_miss, s_rdy;
    logic [31:0] s_pa;
    logic [2:0] s_attr;

    always #(CLK_PERIOD/2) clk = ~clk;

    asid_tlb #(.ENTRIES(8), .PFN_W(PFN_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .flush_wr(flush_wr), .flush_word(flush_word),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_va(lk_va),
        .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_pa(lk_pa), .lk_attr(lk_attr),
        .walk_req(walk_req), .walk_asid(walk_asid), .walk_va(walk_va),
        .fill_valid(fill_valid), .fill_pfn(fill_pfn), .fill_attr(fill_attr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [6:0] a, input logic [19:0] v);
        @(negedge clk);
        lk_valid = 1'b1; lk_asid = a; lk_va = {v, OFS};
        #1;
        s_hit = lk_hit; s_miss = lk_miss; s_rdy = lk_ready;
        s_pa = lk_pa; s_attr = lk_attr;
        @(posedge clk); #1 lk_valid = 1'b0;
    endtask

    task automatic cancel();
        @(negedge clk);
        fill_valid = 1'b1; flush_wr = 1'b1; flush_word = 32'h0000_0001;
        @(posedge clk); #1 fill_valid = 1'b0; flush_wr = 1'b0;
    endtask

    task automatic expect_hit(input logic [6:0] a, input logic [19:0] v,
                              input logic [19:0] pfn, input logic [2:0] at, input string tag);
        look(a, v);
        chk(s_hit === 1'b1 && s_pa === {pfn, OFS}, {tag, " pa"}, s_pa, {pfn, OFS});
        chk(s_attr === at, {tag, " attr"}, {29'd0, s_attr}, {29'd0, at});
    endtask

    task automatic expect_miss(input logic [6:0] a, input logic [19:0] v, input string tag);
        look(a, v);
        chk(s_miss === 1'b1 && s_hit === 1'b0, tag, {30'd0, s_hit, s_miss}, 32'd1);
        cancel();
    endtask

    task automatic finish_fill(input logic [6:0] a, input logic [19:0] v,
                               input logic [19:0] pfn, input logic [2:0] at, input string tag);
        @(negedge clk);
        chk(walk_req === 1'b1 && walk_asid === a && walk_va === {v, 12'h0},
            {tag, " walk"}, walk_va, {v, 12'h0});
        fill_valid = 1'b1; fill_pfn = pfn; fill_attr = at;
        @(posedge clk); #1 fill_valid = 1'b0;
    endtask

    task automatic fill(input logic [6:0] a, input logic [19:0] v,
                        input logic [19:0] pfn, input logic [2:0] at, input string tag);
        look(a, v);
        chk(s_miss === 1'b1, {tag, " miss"}, {31'd0, s_miss}, 32'd1);
        finish_fill(a, v, pfn, at, tag);
    endtask

    task automatic cfg_raw(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_word = w;
        @(posedge clk); #1 cfg_wr = 1'b0;
    endtask

    task automatic cfg(input bit hum, input bit rr, input logic [5:0] lines);
        cfg_raw({2'b00, hum, rr, 22'd0, lines});
    endtask

    task automatic flush(input logic [31:0] w);
        @(negedge clk);
        flush_wr = 1'b1; flush_word = w;
        @(posedge clk); #1 flush_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(lk_ready === 1'b1 && walk_req === 1'b0, "R1 idle after reset",
            {30'd0, lk_ready, walk_req}, 32'd2);
        expect_miss(7'd5, 20'd0, "R1 empty after reset");

        // R2 R3: fill all eight lines, then sweep them
        for (int i = 0; i < 8; i++)
            fill(7'd5, 20'(i), 20'(32'h100 + i), 3'(i), "R3 fill");
        for (int i = 0; i < 8; i++)
            expect_hit(7'd5, 20'(i), 20'(32'h100 + i), 3'(i), "R2 sweep hit");
        expect_miss(7'd6, 20'd3, "R2 identifier mismatch");

        // R4: ninth page evicts line 0
        fill(7'd5, 20'd8, 20'h108, 3'd0, "R4 fill ninth");
        expect_miss(7'd5, 20'd0, "R4 round robin evicted first");
        for (int i = 1; i < 9; i++)
            expect_hit(7'd5, 20'(i), 20'(32'h100 + i), 3'(i), "R4 others kept");

        // R6: hit under miss (default on)
        look(7'd5, 20'd0);
        chk(s_miss === 1'b1, "R6 miss opens walk", {31'd0, s_miss}, 32'd1);
        look(7'd5, 20'd3);
        chk(s_rdy === 1'b1 && s_hit === 1'b1 && s_pa === {20'h103, OFS},
            "R6 hit served while pending", s_pa, {20'h103, OFS});
        look(7'd5, 20'h50);
        chk(s_rdy === 1'b0 && s_miss === 1'b0 && s_hit === 1'b0,
            "R6 miss stalled while pending", {29'd0, s_rdy, s_hit, s_miss}, 32'd0);
        finish_fill(7'd5, 20'd0, 20'h200, 3'd7, "R3 pending fill");
        expect_hit(7'd5, 20'd0, 20'h200, 3'd7, "R3 filled page");
        expect_miss(7'd5, 20'd1, "R4 pointer advanced to line 1");
        expect_hit(7'd5, 20'd2, 20'h102, 3'd2, "R4 line 2 kept");

        // R6: hit under miss off
        cfg(1'b0, 1'b1, 6'd8);
        look(7'd5, 20'h7f);
        chk(s_miss === 1'b1, "R6 miss with hum off", {31'd0, s_miss}, 32'd1);
        look(7'd5, 20'd3);
        chk(s_rdy === 1'b0 && s_hit === 1'b0, "R6 hit stalled with hum off",
            {30'd0, s_rdy, s_hit}, 32'd0);
        finish_fill(7'd5, 20'h7f, 20'h27f, 3'd5, "R3 fill hum off");
        expect_miss(7'd5, 20'd2, "R4 line 2 evicted");
        expect_hit(7'd5, 20'h7f, 20'h27f, 3'd5, "R3 page 7f");
        cfg(1'b1, 1'b1, 6'd8);

        // R8: group flush for another identifier leaves pages alone
        flush(32'h8600_0003);
        expect_hit(7'd5, 20'd3, 20'h103, 3'd3, "R8 other identifier untouched");
        // R7: group flush of pages 4..7
        flush(32'h8500_0007);
        expect_hit(7'd5, 20'd3, 20'h103, 3'd3, "R7 group neighbour kept");
        for (int i = 4; i < 8; i++)
            expect_miss(7'd5, 20'(i), "R7 group dropped");
        expect_hit(7'd5, 20'd8, 20'h108, 3'd0, "R7 next group kept");

        // R5: free-first replacement
        cfg(1'b1, 1'b0, 6'd8);
        fill(7'd9, 20'h400, 20'h300, 3'd1, "R5 fill free a");
        fill(7'd9, 20'h005, 20'h305, 3'd2, "R5 fill free b");
        expect_hit(7'd5, 20'd3, 20'h103, 3'd3, "R5 pointer line kept");
        expect_miss(7'd5, 20'd5, "R2 same page other identifier");
        expect_hit(7'd9, 20'h005, 20'h305, 3'd2, "R5 free fill hit");

        // R7 R8: section flushes
        flush(32'h8900_0002);
        expect_miss(7'd9, 20'h005, "R8 section with identifier dropped");
        expect_hit(7'd9, 20'h400, 20'h300, 3'd1, "R7 other section kept");
        expect_hit(7'd5, 20'd0, 20'h200, 3'd7, "R8 other identifier kept");
        flush(32'h0000_0002);
        expect_miss(7'd5, 20'd0, "R7 section all ids p0");
        expect_miss(7'd5, 20'd3, "R7 section all ids p3");
        expect_miss(7'd5, 20'h7f, "R7 section all ids p7f");
        expect_miss(7'd5, 20'd8, "R7 section all ids p8");
        expect_hit(7'd9, 20'h400, 20'h300, 3'd1, "R7 section one kept");

        // R7 R8: flush all
        flush(32'h8300_0000);
        expect_hit(7'd9, 20'h400, 20'h300, 3'd1, "R8 all for other id");
        flush(32'h8900_0000);
        expect_miss(7'd9, 20'h400, "R8 all for this id");
        cfg(1'b1, 1'b1, 6'd8);
        fill(7'd4, 20'h10, 20'h410, 3'd4, "R3 refill");
        expect_hit(7'd4, 20'h10, 20'h410, 3'd4, "R3 refill hit");
        flush(32'h0010_0000);
        expect_hit(7'd4, 20'h10, 20'h410, 3'd4, "R7 reserved bits ignored");
        flush(32'h0000_0000);
        expect_miss(7'd4, 20'h10, "R7 flush everything");

        // R10: active line count
        cfg(1'b1, 1'b1, 6'd2);
        fill(7'd1, 20'h10, 20'h510, 3'd1, "R10 two lines a");
        fill(7'd1, 20'h11, 20'h511, 3'd2, "R10 two lines b");
        fill(7'd1, 20'h12, 20'h512, 3'd3, "R10 two lines c");
        expect_miss(7'd1, 20'h10, "R10 wrap at two");
        expect_hit(7'd1, 20'h11, 20'h511, 3'd2, "R10 line 1");
        expect_hit(7'd1, 20'h12, 20'h512, 3'd3, "R10 line 0");
        cfg_raw(32'h8000_0001);
        expect_hit(7'd1, 20'h11, 20'h511, 3'd2, "R10 reserved config ignored");
        cfg(1'b1, 1'b1, 6'd1);
        expect_miss(7'd1, 20'h11, "R10 shrink drops upper line");
        expect_hit(7'd1, 20'h12, 20'h512, 3'd3, "R10 lower line kept");
        cfg(1'b1, 1'b1, 6'd0);
        expect_miss(7'd1, 20'h12, "R10 zero lines");
        fill(7'd1, 20'h13, 20'h513, 3'd0, "R10 fill with zero lines");
        expect_miss(7'd1, 20'h13, "R10 nothing stored");
        cfg(1'b1, 1'b1, 6'd63);
        expect_miss(7'd1, 20'h12, "R10 cleared by zero count");
        for (int i = 0; i < 8; i++)
            fill(7'd1, 20'(32'h20 + i), 20'(32'h620 + i), 3'(i), "R10 clamp fill");
        for (int i = 0; i < 8; i++)
            expect_hit(7'd1, 20'(32'h20 + i), 20'(32'h620 + i), 3'(i), "R10 clamp hit");
        fill(7'd1, 20'h28, 20'h628, 3'd6, "R10 clamp ninth");
        expect_miss(7'd1, 20'h20, "R4 clamp wrap evicts");
        expect_hit(7'd1, 20'h21, 20'h621, 3'd1, "R4 clamp neighbour kept");
        expect_hit(7'd1, 20'h28, 20'h628, 3'd6, "R4 clamp ninth hit");

        // R9: flush beats coincident fill
        look(7'd2, 20'h50);
        chk(s_miss === 1'b1, "R9 miss opens walk", {31'd0, s_miss}, 32'd1);
        @(negedge clk);
        fill_valid = 1'b1; fill_pfn = 20'h750; fill_attr = 3'd7;
        flush_wr = 1'b1; flush_word = 32'h8700_0000;
        @(posedge clk); #1 fill_valid = 1'b0; flush_wr = 1'b0;
        @(negedge clk);
        chk(walk_req === 1'b0, "R9 walk closed", {31'd0, walk_req}, 32'd0);
        expect_miss(7'd2, 20'h50, "R9 fill discarded");
        expect_hit(7'd1, 20'h21, 20'h621, 3'd1, "R9 unrelated kept");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule